// File: doc/BRIEF.md
# Flash Rewrite Mode Controller

This block sits between a CPU command port and a small on-chip flash array and sequences the two operations that alter the array: programming a single word and erasing a whole block. Commands arrive as single-cycle writes carrying an opcode, a target address and a data byte. The controller checks each program or erase request against a per-block protection mask and a pair of sticky error flags. It then either starts a timed operation in the array model or rejects the request and raises the matching error flag. A running operation can be paused and later continued.

Two rewrite modes are available, picked by a mode register that only changes while the array is idle. In mode 0 the CPU keeps running during an operation. Once a program or erase has been accepted, reads return the status byte instead of array contents, until software switches the view back. In mode 1 the CPU bus is stalled for the whole of a running operation and reads always return array contents. Mode 1 also refuses program and erase requests aimed at the block that holds the currently executing code, and it has no switch to the status view.

The status byte reports ready (bit 7), suspended (bit 6), erase error (bit 5) and program error (bit 4); bits 3..0 read as zero. Opcodes are: 1 program, 2 block erase, 3 suspend, 4 resume, 5 clear status, 6 show status, 7 show array. The upper address bits select the block and the lower bits select the word within it.

Top module: `flash_rewrite_ctrl`

## Requirements
- R1: After reset the mode is 0, the status byte is 0x80, bus_hold is low and every array word reads 0xFF.
- R2: An accepted program (opcode 1) holds status bit 7 low for exactly PROG_CYC sampled cycles. It then leaves the addressed word equal to its old value ANDed with the command data.
- R3: An accepted block erase (opcode 2) holds status bit 7 low for exactly ERASE_CYC sampled cycles. It then sets every word of the addressed block to all ones and leaves the other blocks unchanged.
- R4: In mode 0, reads return the status byte (zero-extended) while an operation runs or is suspended. They also return it after an accepted program or erase, or after opcode 6, until opcode 7 is taken while idle.
- R5: In mode 1, reads always return array data, including straight after an operation, and opcode 6 has no effect on the read path.
- R6: bus_hold is high exactly while an operation runs in mode 1 and is never high in mode 0.
- R7: In mode 1, a program or erase whose block equals fetch_blk is refused. cmd_reject pulses, the program-error (bit 4) or erase-error (bit 5) flag is set, and the array is unchanged. In mode 0 the same request is accepted.
- R8: A program or erase to a block whose prot_mask bit is set is refused in the same way as R7, and the array is unchanged.
- R9: While either error flag is set, program and erase are refused with a cmd_reject pulse and no operation starts. Opcode 5 clears both flags.
- R10: Suspend (opcode 3) during a running operation freezes its progress and shows status 0x40. Resume (opcode 4) continues it, so busy time before the suspend plus busy time after the resume equals the full operation length.
- R11: Suspend while idle and resume while not suspended have no effect on status.
- R12: A mode write while an operation is running or suspended is ignored; one while idle takes effect.
- R13: Program or erase while running or suspended is ignored without a reject, and any command presented while bus_hold is high is dropped.
- R14: cmd_reject is a one-cycle pulse in the cycle after the edge that takes a refused program or erase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_wr | input | 1 | Mode register write strobe |
| mode_in | input | 1 | Requested rewrite mode (0 or 1) |
| cmd_valid | input | 1 | Command write strobe |
| cmd_op | input | 3 | Command opcode |
| cmd_addr | input | ADDR_W | Target address: block in upper bits, word in lower bits |
| cmd_data | input | DATA_W | Program data |
| fetch_blk | input | BLK_W | Block holding the currently executing code |
| prot_mask | input | NUM_BLK | Per-block write protection |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Read data: array word or status byte |
| bus_hold | output | 1 | CPU bus stall request |
| cmd_reject | output | 1 | Refused program/erase pulse |
| status | output | 8 | Status byte |
| mode_q | output | 1 | Current rewrite mode |

## Verification
The assertions assume that fetch_blk and prot_mask are stable while a command is presented. They also assume cmd_valid is a single-cycle strobe with a defined opcode, and that the CPU offers no commands while bus_hold is high except where that case is the point of a test. The bench drives every input on the falling edge and holds each command for one cycle only. It changes fetch_blk and the protection mask only while no command is in flight, and it presents a command during a hold on purpose just once, to show that it is dropped.

// File: rtl/frc_pkg.sv
package frc_pkg;

  typedef enum logic [2:0] {
    OP_NOP     = 3'd0,
    OP_PROG    = 3'd1,
    OP_ERASE   = 3'd2,
    OP_SUSP    = 3'd3,
    OP_RESUME  = 3'd4,
    OP_CLRSTAT = 3'd5,
    OP_SHOWST  = 3'd6,
    OP_SHOWARR = 3'd7
  } frc_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_SUSP = 2'd2
  } frc_state_e;

  localparam int STAT_READY = 7;
  localparam int STAT_SUSP  = 6;
  localparam int STAT_EERR  = 5;
  localparam int STAT_PERR  = 4;

endpackage

// File: rtl/frc_cmd_decode.sv
module frc_cmd_decode
  import frc_pkg::*;
#(
  parameter int NUM_BLK = 8,
  localparam int BLK_W  = $clog2(NUM_BLK)
) (
  input  logic               valid_i,
  input  logic [2:0]         op_i,
  input  logic [BLK_W-1:0]   blk_i,
  input  logic [BLK_W-1:0]   fetch_blk_i,
  input  logic [NUM_BLK-1:0] prot_i,
  input  logic               mode_i,
  input  logic               hold_i,
  input  logic               idle_i,
  input  logic               err_any_i,
  output logic               start_o,
  output logic               erase_o,
  output logic               set_perr_o,
  output logic               set_eerr_o,
  output logic               reject_o,
  output logic               suspend_o,
  output logic               resume_o,
  output logic               clear_o,
  output logic               show_st_o,
  output logic               show_arr_o
);

  frc_op_e op;
  logic    live;
  logic    is_prog;
  logic    is_erase;
  logic    blocked;
  logic    eligible;

  always_comb begin
    op        = frc_op_e'(op_i);
    live      = valid_i && !hold_i;
    is_prog   = live && (op == OP_PROG);
    is_erase  = live && (op == OP_ERASE);
    blocked   = prot_i[blk_i] || (mode_i && (blk_i == fetch_blk_i));
    eligible  = (is_prog || is_erase) && idle_i;

    start_o    = eligible && !err_any_i && !blocked;
    erase_o    = is_erase;
    set_perr_o = is_prog  && idle_i && !err_any_i && blocked;
    set_eerr_o = is_erase && idle_i && !err_any_i && blocked;
    reject_o   = eligible && (err_any_i || blocked);

    suspend_o  = live && (op == OP_SUSP);
    resume_o   = live && (op == OP_RESUME);
    clear_o    = live && (op == OP_CLRSTAT);
    show_st_o  = live && (op == OP_SHOWST) && !mode_i;
    show_arr_o = live && (op == OP_SHOWARR);
  end

endmodule

// File: rtl/frc_seq.sv
module frc_seq
  import frc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       suspend_i,
  input  logic       resume_i,
  input  logic       done_i,
  output frc_state_e state_o
);

  frc_state_e state_q;
  frc_state_e state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = ST_RUN;
      ST_RUN: begin
        if (done_i)         state_d = ST_IDLE;
        else if (suspend_i) state_d = ST_SUSP;
      end
      ST_SUSP: if (resume_i) state_d = ST_RUN;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state_o = state_q;

  // R10/R11: entering the running state from suspend needs a resume
  a_r10_resume_only_from_susp: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && $past(state_q) == ST_SUSP) |-> $past(resume_i));

  // R11: a suspend while idle never leads straight to the suspended state
  a_r11_no_susp_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SUSP) |-> ($past(state_q) != ST_IDLE));

endmodule

// File: rtl/frc_array.sv
module frc_array #(
  parameter int NUM_BLK   = 8,
  parameter int WORDS     = 4,
  parameter int DATA_W    = 8,
  parameter int PROG_CYC  = 6,
  parameter int ERASE_CYC = 12,
  localparam int BLK_W    = $clog2(NUM_BLK),
  localparam int WRD_W    = $clog2(WORDS),
  localparam int ADDR_W   = BLK_W + WRD_W,
  localparam int DEPTH    = NUM_BLK * WORDS,
  localparam int MAXC     = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC,
  localparam int CNT_W    = $clog2(MAXC + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              erase_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              pause_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              ready_o,
  output logic              done_o
);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              run_q, run_d;
  logic              erase_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              advance;

  always_comb begin
    advance = run_q && !pause_i;
    done_o  = advance && (cnt_q == CNT_W'(1));
    cnt_d   = cnt_q;
    run_d   = run_q;
    if (start_i) begin
      cnt_d = erase_i ? CNT_W'(ERASE_CYC) : CNT_W'(PROG_CYC);
      run_d = 1'b1;
    end else if (done_o) begin
      run_d = 1'b0;
    end else if (advance) begin
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      run_q <= run_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      erase_q <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
    end else if (start_i) begin
      erase_q <= erase_i;
      addr_q  <= addr_i;
      data_q  <= data_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
    end else if (done_o) begin
      if (erase_q) begin
        for (int w = 0; w < WORDS; w++)
          mem_q[{addr_q[ADDR_W-1:WRD_W], w[WRD_W-1:0]}] <= '1;
      end else begin
        mem_q[addr_q] <= mem_q[addr_q] & data_q;
      end
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];
  assign ready_o   = !run_q;

  // R10: progress is frozen while the sequencer holds the operation
  a_r10_frozen_count: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && pause_i && !start_i) |=> $stable(cnt_q));

  // R13: a new start never arrives while an operation is in progress
  a_r13_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> !run_q);

endmodule

// File: rtl/flash_rewrite_ctrl.sv
module flash_rewrite_ctrl
  import frc_pkg::*;
#(
  parameter int NUM_BLK   = 8,
  parameter int WORDS     = 4,
  parameter int DATA_W    = 8,
  parameter int PROG_CYC  = 6,
  parameter int ERASE_CYC = 12,
  localparam int BLK_W    = $clog2(NUM_BLK),
  localparam int WRD_W    = $clog2(WORDS),
  localparam int ADDR_W   = BLK_W + WRD_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mode_wr,
  input  logic               mode_in,
  input  logic               cmd_valid,
  input  logic [2:0]         cmd_op,
  input  logic [ADDR_W-1:0]  cmd_addr,
  input  logic [DATA_W-1:0]  cmd_data,
  input  logic [BLK_W-1:0]   fetch_blk,
  input  logic [NUM_BLK-1:0] prot_mask,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [DATA_W-1:0]  rd_data,
  output logic               bus_hold,
  output logic               cmd_reject,
  output logic [7:0]         status,
  output logic               mode_q
);

  frc_state_e  state;
  logic        idle;
  logic        start, erase_sel, set_perr, set_eerr, reject;
  logic        suspend, resume, clear, show_st, show_arr;
  logic        arr_ready, arr_done;
  logic [DATA_W-1:0] arr_rd;

  logic        mode_d;
  logic        perr_q, perr_d, eerr_q, eerr_d;
  logic        view_q, view_d;
  logic        reject_q;
  logic [DATA_W-1:0] stat_ext;
  logic        status_view;

  assign idle = (state == ST_IDLE);

  frc_cmd_decode #(.NUM_BLK(NUM_BLK)) u_dec (
    .valid_i     (cmd_valid),
    .op_i        (cmd_op),
    .blk_i       (cmd_addr[ADDR_W-1:WRD_W]),
    .fetch_blk_i (fetch_blk),
    .prot_i      (prot_mask),
    .mode_i      (mode_q),
    .hold_i      (bus_hold),
    .idle_i      (idle),
    .err_any_i   (perr_q || eerr_q),
    .start_o     (start),
    .erase_o     (erase_sel),
    .set_perr_o  (set_perr),
    .set_eerr_o  (set_eerr),
    .reject_o    (reject),
    .suspend_o   (suspend),
    .resume_o    (resume),
    .clear_o     (clear),
    .show_st_o   (show_st),
    .show_arr_o  (show_arr)
  );

  frc_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start),
    .suspend_i (suspend),
    .resume_i  (resume),
    .done_i    (arr_done),
    .state_o   (state)
  );

  frc_array #(
    .NUM_BLK   (NUM_BLK),
    .WORDS     (WORDS),
    .DATA_W    (DATA_W),
    .PROG_CYC  (PROG_CYC),
    .ERASE_CYC (ERASE_CYC)
  ) u_arr (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start),
    .erase_i   (erase_sel),
    .addr_i    (cmd_addr),
    .data_i    (cmd_data),
    .pause_i   (state == ST_SUSP),
    .rd_addr_i (rd_addr),
    .rd_data_o (arr_rd),
    .ready_o   (arr_ready),
    .done_o    (arr_done)
  );

  // next-state for the control registers
  always_comb begin
    mode_d = mode_q;
    if (mode_wr && idle) mode_d = mode_in;

    perr_d = perr_q;
    eerr_d = eerr_q;
    if (clear) begin
      perr_d = 1'b0;
      eerr_d = 1'b0;
    end
    if (set_perr) perr_d = 1'b1;
    if (set_eerr) eerr_d = 1'b1;

    view_d = view_q;
    if ((start && !mode_q) || show_st) view_d = 1'b1;
    else if (show_arr && idle)         view_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= 1'b0;
      perr_q   <= 1'b0;
      eerr_q   <= 1'b0;
      view_q   <= 1'b0;
      reject_q <= 1'b0;
    end else begin
      mode_q   <= mode_d;
      perr_q   <= perr_d;
      eerr_q   <= eerr_d;
      view_q   <= view_d;
      reject_q <= reject;
    end
  end

  always_comb begin
    status                = '0;
    status[STAT_READY]    = idle;
    status[STAT_SUSP]     = (state == ST_SUSP);
    status[STAT_EERR]     = eerr_q;
    status[STAT_PERR]     = perr_q;
    stat_ext              = '0;
    stat_ext[7:0]         = status;
    status_view           = !mode_q && (view_q || !idle);
    rd_data               = status_view ? stat_ext : arr_rd;
  end

  assign bus_hold   = mode_q && (state == ST_RUN);
  assign cmd_reject = reject_q;

  // R6: the bus is only held while the array reports an operation in progress
  a_r6_hold_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
    bus_hold |-> !arr_ready);

  // R12: the mode register moves only out of an idle cycle
  a_r12_mode_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != $past(mode_q)) |-> ($past(state) == ST_IDLE));

  // R9: no operation starts while an error flag is pending
  a_r9_no_start_on_error: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !(perr_q || eerr_q));

  // R7: in mode 1 the block of the executing code is never started
  a_r7_self_block_safe: assert property (@(posedge clk) disable iff (!rst_n)
    (start && mode_q) |-> (cmd_addr[ADDR_W-1:WRD_W] != fetch_blk));

  // R14: reject is a single-cycle pulse
  a_r14_reject_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_reject && !reject) |=> !cmd_reject);

endmodule

// File: tb/tb_flash_rewrite_ctrl.sv
`timescale 1ns/1ps
module tb_flash_rewrite_ctrl;

  localparam int PROG_CYC  = 6;
  localparam int ERASE_CYC = 12;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       mode_wr, mode_in, cmd_valid;
  logic [2:0] cmd_op;
  logic [4:0] cmd_addr, rd_addr;
  logic [7:0] cmd_data, rd_data, status;
  logic [2:0] fetch_blk;
  logic [7:0] prot_mask;
  logic       bus_hold, cmd_reject, mode_q;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  flash_rewrite_ctrl #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) dut (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_in(mode_in),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
    .cmd_data(cmd_data), .fetch_blk(fetch_blk), .prot_mask(prot_mask),
    .rd_addr(rd_addr), .rd_data(rd_data), .bus_hold(bus_hold),
    .cmd_reject(cmd_reject), .status(status), .mode_q(mode_q)
  );

  typedef struct packed {
    logic [2:0] op;
    logic [4:0] addr;
    logic [7:0] data;
    logic [7:0] stat;
    logic       rej;
  } vec_t;

  // mode 0, block 7 protected
  localparam vec_t VEC [8] = '{
    '{3'd1, 5'd4,  8'h3C, 8'h80, 1'b0},  // R2 program accepted
    '{3'd1, 5'd28, 8'h00, 8'h90, 1'b1},  // R8 protected program
    '{3'd1, 5'd4,  8'hF0, 8'h90, 1'b1},  // R9 refused on pending error
    '{3'd5, 5'd0,  8'h00, 8'h80, 1'b0},  // R9 clear status
    '{3'd2, 5'd28, 8'h00, 8'hA0, 1'b1},  // R8 protected erase
    '{3'd5, 5'd0,  8'h00, 8'h80, 1'b0},  // R9 clear status
    '{3'd2, 5'd5,  8'h00, 8'h80, 1'b0},  // R3 erase block 1
    '{3'd1, 5'd6,  8'h5A, 8'h80, 1'b0}   // R2 program after erase
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op, input logic [4:0] a,
                       input logic [7:0] d, output logic rej);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    rej = cmd_reject;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (status[7] == 1'b0 && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic write_mode(input logic m);
    mode_wr = 1'b1; mode_in = m;
    @(posedge clk);
    @(negedge clk);
    mode_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
  end

  initial begin
    logic       rej;
    logic [7:0] d;
    int         n;
    rst_n = 1'b0; mode_wr = 0; mode_in = 0; cmd_valid = 0; cmd_op = 0;
    cmd_addr = 0; cmd_data = 0; fetch_blk = 0; prot_mask = 8'h80; rd_addr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 status", status, 8'h80);
    chk("R1 mode", mode_q, 0);
    chk("R1 hold", bus_hold, 0);
    rd(5'd0, d);  chk("R1 array word 0", d, 8'hFF);
    rd(5'd31, d); chk("R1 array word 31", d, 8'hFF);

    // vector table
    for (int i = 0; i < 8; i++) begin
      issue(VEC[i].op, VEC[i].addr, VEC[i].data, rej);
      chk($sformatf("R14 vec%0d reject", i), rej, VEC[i].rej);
      wait_idle(n);
      chk($sformatf("R9 vec%0d status", i), status, VEC[i].stat);
    end
    issue(3'd7, 0, 0, rej);
    rd(5'd4, d);  chk("R3 erased word", d, 8'hFF);
    rd(5'd5, d);  chk("R3 erased word 5", d, 8'hFF);
    rd(5'd6, d);  chk("R2 programmed word", d, 8'h5A);
    rd(5'd28, d); chk("R8 protected untouched", d, 8'hFF);

    // R2 timing and AND semantics, R4 status view
    issue(3'd1, 5'd8, 8'h0F, rej);
    chk("R2 busy after accept", status[7], 0);
    rd(5'd8, d); chk("R4 status view while busy", d, 8'h00);
    chk("R6 no hold in mode 0", bus_hold, 0);
    wait_idle(n);
    chk("R2 program length", n, PROG_CYC);
    rd(5'd8, d); chk("R4 status view after done", d, 8'h80);
    issue(3'd7, 0, 0, rej);
    rd(5'd8, d); chk("R2 programmed value", d, 8'h0F);
    issue(3'd1, 5'd8, 8'hF3, rej);
    wait_idle(n);
    issue(3'd7, 0, 0, rej);
    rd(5'd8, d); chk("R2 AND of old and new", d, 8'h03);

    // R3 erase length
    issue(3'd2, 5'd9, 0, rej);
    wait_idle(n);
    chk("R3 erase length", n, ERASE_CYC);
    issue(3'd7, 0, 0, rej);
    rd(5'd8, d); chk("R3 block erased", d, 8'hFF);
    rd(5'd6, d); chk("R3 other block kept", d, 8'h5A);

    // R11 suspend/resume when idle
    issue(3'd3, 0, 0, rej);
    chk("R11 suspend idle", status, 8'h80);
    issue(3'd4, 0, 0, rej);
    chk("R11 resume idle", status, 8'h80);

    // R10 suspend and resume
    issue(3'd2, 5'd12, 0, rej);
    repeat (3) @(negedge clk);
    issue(3'd3, 0, 0, rej);
    chk("R10 suspended status", status, 8'h40);
    repeat (4) @(negedge clk);
    chk("R10 still suspended", status, 8'h40);
    rd(5'd12, d); chk("R4 status view while suspended", d, 8'h40);
    issue(3'd7, 0, 0, rej);
    rd(5'd12, d); chk("R4 show-array refused while suspended", d, 8'h40);
    issue(3'd4, 0, 0, rej);
    wait_idle(n);
    chk("R10 remaining length", n, ERASE_CYC - 4);

    // R13 program while busy ignored
    issue(3'd1, 5'd16, 8'h11, rej);
    issue(3'd1, 5'd17, 8'h22, rej);
    chk("R13 no reject while busy", rej, 0);
    wait_idle(n);
    issue(3'd7, 0, 0, rej);
    rd(5'd17, d); chk("R13 ignored program", d, 8'hFF);
    rd(5'd16, d); chk("R2 first program", d, 8'h11);

    // R12 mode write while busy ignored
    issue(3'd1, 5'd18, 8'h00, rej);
    write_mode(1'b1);
    chk("R12 mode kept while busy", mode_q, 0);
    wait_idle(n);
    write_mode(1'b1);
    chk("R12 mode set when idle", mode_q, 1);

    // mode 1
    fetch_blk = 3'd3;
    rd(5'd16, d); chk("R5 array read in mode 1", d, 8'h11);
    issue(3'd1, 5'd20, 8'h77, rej);
    chk("R6 hold in mode 1", bus_hold, 1);
    issue(3'd3, 0, 0, rej);
    chk("R13 suspend dropped during hold", status, 8'h00);
    wait_idle(n);
    chk("R6 hold length", n, PROG_CYC - 1);
    chk("R6 hold released", bus_hold, 0);
    rd(5'd20, d); chk("R5 array after op", d, 8'h77);
    issue(3'd6, 0, 0, rej);
    rd(5'd20, d); chk("R5 show-status ignored", d, 8'h77);

    // R7 self-targeting
    issue(3'd1, 5'd12, 8'h00, rej);
    chk("R7 program reject", rej, 1);
    chk("R7 program error", status, 8'h90);
    rd(5'd12, d); chk("R7 array unchanged", d, 8'hFF);
    issue(3'd5, 0, 0, rej);
    issue(3'd2, 5'd13, 0, rej);
    chk("R7 erase reject", rej, 1);
    chk("R7 erase error", status, 8'hA0);
    issue(3'd5, 0, 0, rej);
    chk("R9 cleared", status, 8'h80);

    // mode 0 accepts the same block
    write_mode(1'b0);
    issue(3'd1, 5'd12, 8'h00, rej);
    chk("R7 accepted in mode 0", rej, 0);
    chk("R6 no hold mode 0", bus_hold, 0);
    wait_idle(n);
    issue(3'd7, 0, 0, rej);
    rd(5'd12, d); chk("R7 mode 0 programmed", d, 8'h00);

    summary();
  end

endmodule